// File: doc/BRIEF.md
# Two-Module Cache Tag Controller with Conflict-Bit Victim Choice

This block holds the tag and replacement state of a level-1 data cache that is built from two parallel modules. Module A is a set-associative array of 128 sets with 3 ways each. Module B is a small fully associative buffer of 32 entries. Both modules hold 32-byte blocks. Every lookup probes both modules in the same cycle. The block reports whether the access hit and which module holds the block. Data storage is not part of this block, and neither are write-back traffic or coherence.

On a miss the controller asks the next memory level for the block through a request/acknowledge pair, and it allocates the block when the acknowledge arrives. Reads and writes are handled the same way.

Each A-module block carries one conflict bit. A referenced block clears its bit. A miss to a set raises the bits of every block resident in that set. When a set is full, a block whose bit is still raised has not been used since the previous miss to its set, so it is evicted. If no such block exists, the incoming block goes into module B and displaces the least recently used entry there.

Top module: `dualmod_cache_ctl`

## Requirements
- R1: Both modules are looked up in the cycle of an accepted request. `resp_hit` and `resp_in_b` are valid combinationally in that cycle. `resp_in_b` is 1 when the block sits in module B and 0 when it sits in module A. No block is ever present in both modules.
- R2: On an accepted miss, `refill_req` rises at the next clock edge. While it is high, `refill_addr` holds the full byte address of the miss and `refill_write` holds its write flag, and both stay stable until a cycle with `refill_ack` high. The block is allocated at that edge, and `req_ready` returns to 1 in the following cycle.
- R3: A write that misses allocates its block exactly as a read miss does. A later read to that block hits.
- R4: The address is split as follows: the byte offset is bits [4:0], the A-set index is bits [11:5] and the A tag is bits [31:12]. Module B compares bits [31:5]. Any byte of an allocated block hits.
- R5: A miss whose A-set has an empty way places the block in the lowest-numbered empty way of module A.
- R6: A hit to an A block clears that block's conflict bit, and a newly placed A block starts with the bit cleared.
- R7: A miss sets the conflict bit of every valid block in its A-set. The victim decision for that miss uses the bit values from before this update.
- R8: When the A-set is full and at least one block has its conflict bit set, the lowest-numbered such way is replaced by the incoming block, and the block stays in module A.
- R9: When the A-set is full and no conflict bit is set, the block goes to module B. It takes an empty B entry if there is one, and otherwise the least recently used entry. A B hit or a B fill makes that entry the most recently used.
- R10: While a refill is pending, `req_ready` is 0 and requests are ignored: no hit is reported and no state changes.
- R11: After reset both modules are empty, `req_ready` is 1 and `refill_req` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Lookup request strobe |
| req_addr | input | 32 | Byte address of the access |
| req_write | input | 1 | 1 for a write access, 0 for a read |
| req_ready | output | 1 | Controller can accept a lookup |
| resp_hit | output | 1 | Accepted lookup hit in either module |
| resp_in_b | output | 1 | Hit was found in module B |
| refill_req | output | 1 | Miss refill pending towards next level |
| refill_addr | output | 32 | Byte address of the pending miss |
| refill_write | output | 1 | Write flag of the pending miss |
| refill_ack | input | 1 | Next level delivers the block; allocate now |

## Verification
A conflict bit that is wrong, or a B-module age order that is wrong, cannot be seen when it happens. It shows up later as a wrong placement. The next miss to the same set (or the next B eviction) picks the wrong victim, so a block that should have stayed resident misses on its next reference, or a block that should have reached module A reports `resp_in_b`. The directed sequences therefore set up known bit patterns and then probe each resident block right after the deciding miss. An error appears within one or two accesses after that miss. Handshake faults show directly on `refill_req`, `refill_addr` and `req_ready` in the cycle after a miss.

// File: rtl/dmc_pkg.sv
`timescale 1ns/1ps
package dmc_pkg;

  typedef enum logic {ST_IDLE = 1'b0, ST_FILL = 1'b1} dmc_state_e;

  typedef enum logic [1:0] {
    PL_A_EMPTY    = 2'd0,
    PL_A_CONFLICT = 2'd1,
    PL_B          = 2'd2
  } dmc_place_e;

  // index width for n items, never below 1
  function automatic int ceil_log2(input int n);
    int r;
    r = 1;
    while ((1 << r) < n) r++;
    return r;
  endfunction

endpackage

// File: rtl/dmc_amod.sv
`timescale 1ns/1ps
module dmc_amod
  import dmc_pkg::*;
#(
  parameter int SETS  = 128,
  parameter int WAYS  = 3,
  parameter int TAG_W = 20,
  parameter int IDX_W = ceil_log2(SETS),
  parameter int WAY_W = ceil_log2(WAYS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] lk_idx,
  input  logic [TAG_W-1:0] lk_tag,
  output logic             hit,
  output logic             has_empty,
  output logic [WAY_W-1:0] empty_way,
  output logic             has_conflict,
  output logic [WAY_W-1:0] conflict_way,
  input  logic             touch_en,
  input  logic             mark_en,
  input  logic             fill_en,
  input  logic [IDX_W-1:0] fill_idx,
  input  logic [WAY_W-1:0] fill_way,
  input  logic [TAG_W-1:0] fill_tag
);

  logic [TAG_W-1:0] tag_q [SETS][WAYS];
  logic [WAYS-1:0]  vld_q [SETS];
  logic [WAYS-1:0]  cfl_q [SETS];
  logic [WAY_W-1:0] hit_way;

  // descending scan: the lowest qualifying way is written last
  always_comb begin
    hit          = 1'b0;
    hit_way      = '0;
    has_empty    = 1'b0;
    empty_way    = '0;
    has_conflict = 1'b0;
    conflict_way = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (vld_q[lk_idx][w] && (tag_q[lk_idx][w] == lk_tag)) begin
        hit     = 1'b1;
        hit_way = WAY_W'(w);
      end
      if (!vld_q[lk_idx][w]) begin
        has_empty = 1'b1;
        empty_way = WAY_W'(w);
      end
      if (vld_q[lk_idx][w] && cfl_q[lk_idx][w]) begin
        has_conflict = 1'b1;
        conflict_way = WAY_W'(w);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) begin
        vld_q[s] <= '0;
        cfl_q[s] <= '0;
      end
    end else begin
      if (touch_en) cfl_q[lk_idx][hit_way] <= 1'b0;
      if (mark_en)  cfl_q[lk_idx] <= cfl_q[lk_idx] | vld_q[lk_idx];
      if (fill_en) begin
        vld_q[fill_idx][fill_way] <= 1'b1;
        cfl_q[fill_idx][fill_way] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (fill_en) tag_q[fill_idx][fill_way] <= fill_tag;
  end

endmodule

// File: rtl/dmc_bmod.sv
`timescale 1ns/1ps
module dmc_bmod
  import dmc_pkg::*;
#(
  parameter int ENT   = 32,
  parameter int TAG_W = 27,
  parameter int IDX_W = ceil_log2(ENT)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [TAG_W-1:0] lk_tag,
  output logic             hit,
  input  logic             touch_en,
  input  logic             fill_en,
  input  logic [TAG_W-1:0] fill_tag
);

  localparam logic [IDX_W-1:0] OLDEST = IDX_W'(ENT - 1);

  logic [TAG_W-1:0] tag_q [ENT];
  logic [ENT-1:0]   vld_q;
  logic [IDX_W-1:0] age_q [ENT];   // 0 = most recent, ENT-1 = least recent
  logic [IDX_W-1:0] hit_idx, victim_idx, upd_idx;
  logic             has_empty;

  always_comb begin
    hit        = 1'b0;
    hit_idx    = '0;
    has_empty  = 1'b0;
    victim_idx = '0;
    for (int i = ENT - 1; i >= 0; i--) begin
      if (vld_q[i] && (tag_q[i] == lk_tag)) begin
        hit     = 1'b1;
        hit_idx = IDX_W'(i);
      end
    end
    for (int i = ENT - 1; i >= 0; i--) begin
      if (!vld_q[i]) begin
        has_empty  = 1'b1;
        victim_idx = IDX_W'(i);
      end
    end
    if (!has_empty) begin
      for (int i = 0; i < ENT; i++) begin
        if (age_q[i] == OLDEST) victim_idx = IDX_W'(i);
      end
    end
  end

  assign upd_idx = fill_en ? victim_idx : hit_idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
      for (int i = 0; i < ENT; i++) age_q[i] <= IDX_W'(i);
    end else begin
      if (touch_en || fill_en) begin
        for (int i = 0; i < ENT; i++) begin
          if (IDX_W'(i) == upd_idx)          age_q[i] <= '0;
          else if (age_q[i] < age_q[upd_idx]) age_q[i] <= age_q[i] + 1'b1;
        end
      end
      if (fill_en) vld_q[victim_idx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (fill_en) tag_q[victim_idx] <= fill_tag;
  end

endmodule

// File: rtl/dualmod_cache_ctl.sv
`timescale 1ns/1ps
module dualmod_cache_ctl
  import dmc_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int BLK_BYTES = 32,
  parameter int A_SETS    = 128,
  parameter int A_WAYS    = 3,
  parameter int B_ENTRIES = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_write,
  output logic              req_ready,
  output logic              resp_hit,
  output logic              resp_in_b,
  output logic              refill_req,
  output logic [ADDR_W-1:0] refill_addr,
  output logic              refill_write,
  input  logic              refill_ack
);

  localparam int OFF_W = ceil_log2(BLK_BYTES);
  localparam int IDX_W = ceil_log2(A_SETS);
  localparam int AT_W  = ADDR_W - OFF_W - IDX_W;
  localparam int BT_W  = ADDR_W - OFF_W;
  localparam int AW_W  = ceil_log2(A_WAYS);

  dmc_state_e        state_q;
  dmc_place_e        place_d, place_q;
  logic [AW_W-1:0]   way_d, way_q;
  logic [ADDR_W-1:0] miss_addr_q;
  logic              miss_wr_q;

  // internal events, brought out for the checker
  logic a_hit, b_hit, accept, miss_acc, fill_go;
  logic a_has_empty, a_has_conflict;
  logic [AW_W-1:0] a_empty_way, a_conflict_way;

  assign accept   = req_valid && (state_q == ST_IDLE);
  assign miss_acc = accept && !(a_hit || b_hit);
  assign fill_go  = (state_q == ST_FILL) && refill_ack;

  dmc_amod #(.SETS(A_SETS), .WAYS(A_WAYS), .TAG_W(AT_W), .IDX_W(IDX_W), .WAY_W(AW_W)) u_amod (
    .clk          (clk),
    .rst_n        (rst_n),
    .lk_idx       (req_addr[OFF_W +: IDX_W]),
    .lk_tag       (req_addr[ADDR_W-1 -: AT_W]),
    .hit          (a_hit),
    .has_empty    (a_has_empty),
    .empty_way    (a_empty_way),
    .has_conflict (a_has_conflict),
    .conflict_way (a_conflict_way),
    .touch_en     (accept && a_hit),
    .mark_en      (miss_acc),
    .fill_en      (fill_go && (place_q != PL_B)),
    .fill_idx     (miss_addr_q[OFF_W +: IDX_W]),
    .fill_way     (way_q),
    .fill_tag     (miss_addr_q[ADDR_W-1 -: AT_W])
  );

  dmc_bmod #(.ENT(B_ENTRIES), .TAG_W(BT_W)) u_bmod (
    .clk      (clk),
    .rst_n    (rst_n),
    .lk_tag   (req_addr[ADDR_W-1 -: BT_W]),
    .hit      (b_hit),
    .touch_en (accept && b_hit),
    .fill_en  (fill_go && (place_q == PL_B)),
    .fill_tag (miss_addr_q[ADDR_W-1 -: BT_W])
  );

  // placement priority: empty A way, then raised conflict bit, then module B
  always_comb begin
    place_d = PL_B;
    way_d   = '0;
    if (a_has_empty) begin
      place_d = PL_A_EMPTY;
      way_d   = a_empty_way;
    end else if (a_has_conflict) begin
      place_d = PL_A_CONFLICT;
      way_d   = a_conflict_way;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      place_q     <= PL_A_EMPTY;
      way_q       <= '0;
      miss_addr_q <= '0;
      miss_wr_q   <= 1'b0;
    end else if (miss_acc) begin
      state_q     <= ST_FILL;
      place_q     <= place_d;
      way_q       <= way_d;
      miss_addr_q <= req_addr;
      miss_wr_q   <= req_write;
    end else if (fill_go) begin
      state_q <= ST_IDLE;
    end
  end

  assign req_ready    = (state_q == ST_IDLE);
  assign resp_hit     = accept && (a_hit || b_hit);
  assign resp_in_b    = accept && b_hit;
  assign refill_req   = (state_q == ST_FILL);
  assign refill_addr  = miss_addr_q;
  assign refill_write = miss_wr_q;

endmodule

// File: rtl/dmc_chk.sv
`timescale 1ns/1ps
module dmc_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              resp_hit,
  input logic              resp_in_b,
  input logic              refill_req,
  input logic              refill_ack,
  input logic [ADDR_W-1:0] refill_addr,
  input logic              hit_a,
  input logic              hit_b
);

  // R1
  single_module_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(hit_a && hit_b));

  // R1
  b_flag_needs_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resp_in_b |-> resp_hit);

  // R2
  miss_starts_refill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !resp_hit) |=> refill_req);

  // R2
  refill_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (refill_req && !refill_ack) |=> refill_req);

  // R2
  refill_addr_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (refill_req && !refill_ack) |=> $stable(refill_addr));

  // R2
  fill_reopens_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (refill_req && refill_ack) |=> (req_ready && !refill_req));

  // R10
  busy_no_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_ready |-> !resp_hit);

endmodule

bind dualmod_cache_ctl dmc_chk #(.ADDR_W(ADDR_W)) u_dmc_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_valid   (req_valid),
  .req_ready   (req_ready),
  .resp_hit    (resp_hit),
  .resp_in_b   (resp_in_b),
  .refill_req  (refill_req),
  .refill_ack  (refill_ack),
  .refill_addr (refill_addr),
  .hit_a       (a_hit),
  .hit_b       (b_hit)
);

// File: tb/dualmod_cache_ctl_bench.sv
`timescale 1ns/1ps
module dualmod_cache_ctl_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [31:0] req_addr = '0;
  logic        req_write = 1'b0;
  logic        req_ready, resp_hit, resp_in_b;
  logic        refill_req, refill_write;
  logic [31:0] refill_addr;
  logic        refill_ack = 1'b0;

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  dualmod_cache_ctl u_dualmod_cache_ctl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_write(req_write), .req_ready(req_ready), .resp_hit(resp_hit),
    .resp_in_b(resp_in_b), .refill_req(refill_req), .refill_addr(refill_addr),
    .refill_write(refill_write), .refill_ack(refill_ack)
  );

  function automatic logic [31:0] mk(input int tg, input int st);
    return {tg[19:0], st[6:0], 5'b00000};
  endfunction

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", rq, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; req_valid = 1'b0; refill_ack = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  // one access; completes the refill if it misses
  task automatic access(input logic [31:0] a, input logic wr, output logic h, output logic b);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_write = wr;
    #1;
    h = resp_hit; b = resp_in_b;
    @(negedge clk);
    req_valid = 1'b0;
    if (!h) begin
      chk("R2 refill_req after miss", refill_req, 1);
      chk("R2 refill_addr", refill_addr, a);
      chk("R2 refill_write", refill_write, wr);
      chk("R2 ready low while pending", req_ready, 0);
      refill_ack = 1'b1;
      @(negedge clk);
      refill_ack = 1'b0;
      chk("R2 ready after fill", req_ready, 1);
      chk("R2 refill_req dropped", refill_req, 0);
    end
  endtask

  task automatic probe(input logic [31:0] a, input logic wr, input logic eh,
                       input logic eb, input string rq);
    logic h, b;
    access(a, wr, h, b);
    chk(rq, h, eh);
    if (eh) chk(rq, b, eb);
  endtask

  task automatic t_reset();
    do_reset();
    #1;
    chk("R11 ready after reset", req_ready, 1);
    chk("R11 no refill after reset", refill_req, 0);
    chk("R11 no hit when idle", resp_hit, 0);
    probe(mk(7, 3), 0, 0, 0, "R11 empty cache misses");
  endtask

  task automatic t_basic();
    do_reset();
    probe(mk(1, 3) | 32'h1c, 1, 0, 0, "R3 write miss");
    probe(mk(1, 3) | 32'h04, 0, 1, 0, "R3 R4 read hits written block in A");
    probe(mk(1, 4), 0, 0, 0, "R4 other set misses");
    probe(mk(2, 3), 0, 0, 0, "R4 other tag misses");
    probe(mk(2, 3), 0, 1, 0, "R5 second way filled in A");
    probe(mk(1, 3), 0, 1, 0, "R5 first way kept");
  endtask

  task automatic t_conflict();
    do_reset();
    probe(mk(11, 5), 0, 0, 0, "R5 fill way0");
    probe(mk(12, 5), 0, 0, 0, "R5 fill way1");
    probe(mk(13, 5), 0, 0, 0, "R5 fill way2");
    probe(mk(11, 5), 0, 1, 0, "R6 hit clears t1");
    probe(mk(12, 5), 0, 1, 0, "R6 hit clears t2");
    probe(mk(14, 5), 0, 0, 0, "R7 miss with no bits");
    probe(mk(14, 5), 0, 1, 1, "R7 R9 block went to B");
    probe(mk(11, 5), 0, 1, 0, "R6 t1 still in A");
    probe(mk(15, 5), 0, 0, 0, "R8 miss with bits raised");
    probe(mk(15, 5), 0, 1, 0, "R8 new block in A");
    probe(mk(13, 5), 0, 1, 0, "R8 lowest conflict way taken");
    probe(mk(11, 5), 0, 1, 0, "R6 cleared block kept");
    probe(mk(12, 5), 0, 0, 0, "R8 evicted block misses");
    probe(mk(12, 5), 0, 1, 1, "R9 evicted block refetched to B");
  endtask

  task automatic refresh9();
    for (int r = 0; r < 3; r++) probe(mk(r + 1, 9), 0, 1, 0, "R6 refresh resident");
  endtask

  task automatic t_lru();
    do_reset();
    for (int r = 0; r < 3; r++) probe(mk(r + 1, 9), 0, 0, 0, "R5 fill set 9");
    for (int k = 0; k < 32; k++) begin
      refresh9();
      probe(mk(100 + k, 9), 0, 0, 0, "R9 fill empty B entry");
    end
    probe(mk(100, 9), 0, 1, 1, "R9 oldest B entry hit");
    refresh9();
    probe(mk(200, 9), 0, 0, 0, "R9 miss with B full");
    probe(mk(200, 9), 0, 1, 1, "R9 new block in B");
    probe(mk(100, 9), 0, 1, 1, "R9 recently used entry kept");
    probe(mk(102, 9), 0, 1, 1, "R9 other entry kept");
    probe(mk(101, 9), 0, 0, 0, "R9 LRU entry evicted");
  endtask

  task automatic t_busy();
    logic h, b;
    do_reset();
    probe(mk(4, 20), 0, 0, 0, "R10 preload");
    @(negedge clk);
    req_valid = 1'b1; req_addr = mk(5, 20); req_write = 1'b0;
    @(negedge clk);
    req_addr = mk(4, 20);
    for (int c = 0; c < 3; c++) begin
      #1;
      chk("R10 ready low while pending", req_ready, 0);
      chk("R10 no hit while pending", resp_hit, 0);
      chk("R2 refill held", refill_req, 1);
      chk("R2 refill addr held", refill_addr, mk(5, 20));
      @(negedge clk);
    end
    req_valid = 1'b0;
    refill_ack = 1'b1;
    @(negedge clk);
    refill_ack = 1'b0;
    chk("R2 ready after ack", req_ready, 1);
    access(mk(5, 20), 0, h, b);
    chk("R10 miss block filled", h, 1);
    access(mk(4, 20), 0, h, b);
    chk("R10 ignored request left A state", {h, b}, 2'b10);
  endtask

  initial begin
    t_reset();
    t_basic();
    t_conflict();
    t_lru();
    t_busy();
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!finished) begin
      n_tests++;
      n_fail++;
      $display("FAIL R2 watchdog act=hung exp=done");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule